// File: doc/BRIEF.md
# Transmit Command and Status Register

This block is the command and status word of a serial transmitter. It sits in a CPU register file. A CPU write puts a 4-bit command in the top nibble of the word. The block decodes that nibble into single-cycle pulses for the transmitter, the CRC generator and the character-stuffing logic. Some commands are allowed only in certain line modes and are dropped in the others. Three commands pick which status source a companion interrupt-control register shows in its high byte, and that choice is held until it is changed. The same write also loads a 3-bit idle-line select and an underrun-wait control bit.

A read returns a mix of two kinds of bit. Six are sticky event flags: a pulse on the matching event input sets the flag, and it stays set until software writes a one to that bit position. The other two follow live status inputs directly: the last bit has left the line, and the FIFO is empty. The transmitter datapath, the CRC engine and the interrupt controller are outside this block. They connect through pulse and level ports.

Top module: `tx_cmd_status`

## Requirements
- R1: After reset, `rd_data_o` reads zero in every stored bit, `idle_sel_o`, `under_wait_o` and `hi_sel_o` are zero, and no command pulse is active.
- R2: A write loads bits 10..8 into `idle_sel_o` and bit 11 into `under_wait_o`. Both read back in those positions and hold until the next write.
- R3: Bits 15..12 of `rd_data_o` always read zero.
- R4: Command code 4'b0010 gives a one-cycle `crc_clr_o` pulse in every mode. The pulse is active in the cycle after the write edge.
- R5: Codes 4'b0101, 4'b0110 and 4'b0111 set `hi_sel_o` to 0 (FIFO status), 1 (interrupt level) and 2 (request level). The value holds until another of these codes is written.
- R6: Code 4'b1000 pulses `send_frame_o` only when `frame_en_i` is 1 at the write; otherwise it is ignored.
- R7: Code 4'b1001 pulses `send_abort_o` only when `mode_i` is 2'b10 (bit-oriented framing); otherwise it is ignored.
- R8: Codes 4'b1100 and 4'b1101 pulse `dle_on_o` and `dle_off_o` only when `mode_i` is 2'b11 (transparent character-sync); otherwise they are ignored.
- R9: Codes 4'b1110 and 4'b1111 pulse `eom_clr_o` and `eom_set_o` only in a synchronous mode (`mode_i` not 2'b00); otherwise they are ignored.
- R10: Codes 4'b0000, 4'b0001, 4'b0011, 4'b0100, 4'b1010 and 4'b1011 produce no pulse and leave `hi_sel_o` unchanged.
- R11: A pulse on an event input sets its sticky flag in the cycle after the edge. The flags and their read bits are: preamble 7, idle 6, abort 5, end-of-message 4, CRC 3, underrun 1. A flag stays set until a write with a one in its bit; a zero there leaves it unchanged.
- R12: When an event and a write-one-to-clear of the same flag fall in the same cycle, the flag ends up set.
- R13: Bit 2 reads `all_sent_i` and bit 0 reads `fifo_empty_i` combinationally. Writes to those bits have no effect.
- R14: At most one command pulse is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data word |
| rd_data_o | output | 16 | Read data word |
| mode_i | input | 2 | Line mode: 00 async, 01 sync, 10 bit-oriented framing, 11 transparent character-sync |
| frame_en_i | input | 1 | Companion control bit enabling the send-frame command |
| ev_pre_i | input | 1 | Preamble finished pulse |
| ev_idle_i | input | 1 | Idle condition sent pulse |
| ev_abort_i | input | 1 | Abort sent pulse |
| ev_eom_i | input | 1 | End of frame/message sent pulse |
| ev_crc_i | input | 1 | CRC sent pulse |
| ev_under_i | input | 1 | Transmit underflow pulse |
| all_sent_i | input | 1 | Live: last bit has left the line |
| fifo_empty_i | input | 1 | Live: transmit FIFO empty |
| crc_clr_o | output | 1 | Clear CRC generator pulse |
| send_frame_o | output | 1 | Send frame/message pulse |
| send_abort_o | output | 1 | Send abort pulse |
| dle_on_o | output | 1 | Enable DLE insertion pulse |
| dle_off_o | output | 1 | Disable DLE insertion pulse |
| eom_clr_o | output | 1 | Clear end-of-message pulse |
| eom_set_o | output | 1 | Set end-of-message pulse |
| hi_sel_o | output | 2 | Held select for the companion register high byte |
| idle_sel_o | output | 3 | Idle-line condition select |
| under_wait_o | output | 1 | Underrun-wait control |

## Verification
The assertions assume that `mode_i` and `frame_en_i` are stable across the write edge they qualify. They also assume that every event input is a synchronous level sampled once per clock. The stimulus changes all inputs only on the falling edge and holds them through the next rising edge, so each write sees exactly one mode. The stimulus draws all sixteen command codes and all four modes at random. Event pulses are drawn often enough that writes clearing a flag regularly land in the same cycle as its event.

// File: rtl/txcsr_pkg.sv
package txcsr_pkg;

   typedef enum logic [1:0] {
      TM_ASYNC   = 2'b00,
      TM_SYNC    = 2'b01,
      TM_HDLC    = 2'b10,
      TM_TBISYNC = 2'b11
   } txmode_e;

   localparam int P_CRC     = 0;
   localparam int P_FRAME   = 1;
   localparam int P_ABORT   = 2;
   localparam int P_DLEON   = 3;
   localparam int P_DLEOFF  = 4;
   localparam int P_EOMCLR  = 5;
   localparam int P_EOMSET  = 6;
   localparam int NUM_PULSE = 7;

   localparam int NUM_FLAG = 6;
   localparam int FLAG_POS [NUM_FLAG] = '{7, 6, 5, 4, 3, 1};

   localparam int BIT_EMPTY   = 0;
   localparam int BIT_ALLSENT = 2;

   localparam logic [1:0] HS_FIFO = 2'd0;
   localparam logic [1:0] HS_INT  = 2'd1;
   localparam logic [1:0] HS_REQ  = 2'd2;

endpackage

// File: rtl/txcsr_cmd_dec.sv
module txcsr_cmd_dec
   import txcsr_pkg::*;
#(
   parameter int CMD_W      = 4,
   parameter int SEL_W      = 2,
   parameter bit REG_PULSES = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [CMD_W-1:0]     cmd,
   input  logic [1:0]           mode,
   input  logic                 frame_en,
   output logic [NUM_PULSE-1:0] pulse,
   output logic [SEL_W-1:0]     hi_sel
);

   logic [NUM_PULSE-1:0] dec;
   logic                 sel_wr;
   logic [SEL_W-1:0]     sel_val;
   logic [SEL_W-1:0]     hi_sel_q;
   logic                 is_sync;

   assign is_sync = (mode != TM_ASYNC);

   always_comb begin
      dec     = '0;
      sel_wr  = 1'b0;
      sel_val = hi_sel_q;
      if (wr_en) begin
         case (cmd)
            4'b0010: dec[P_CRC]    = 1'b1;
            4'b0101: begin sel_wr = 1'b1; sel_val = SEL_W'(HS_FIFO); end
            4'b0110: begin sel_wr = 1'b1; sel_val = SEL_W'(HS_INT);  end
            4'b0111: begin sel_wr = 1'b1; sel_val = SEL_W'(HS_REQ);  end
            4'b1000: dec[P_FRAME]  = frame_en;
            4'b1001: dec[P_ABORT]  = (mode == TM_HDLC);
            4'b1100: dec[P_DLEON]  = (mode == TM_TBISYNC);
            4'b1101: dec[P_DLEOFF] = (mode == TM_TBISYNC);
            4'b1110: dec[P_EOMCLR] = is_sync;
            4'b1111: dec[P_EOMSET] = is_sync;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         hi_sel_q <= '0;
      else if (sel_wr)
         hi_sel_q <= sel_val;
   end

   assign hi_sel = hi_sel_q;

   generate
      if (REG_PULSES) begin : g_reg
         logic [NUM_PULSE-1:0] pulse_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               pulse_q <= '0;
            else
               pulse_q <= dec;
         end
         assign pulse = pulse_q;
      end else begin : g_comb
         assign pulse = dec;
      end
   endgenerate

endmodule

// File: rtl/txcsr_flags.sv
module txcsr_flags #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_cell
         logic f_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               f_q <= 1'b0;
            else if (set[i])
               f_q <= 1'b1;
            else if (clr[i])
               f_q <= 1'b0;
         end
         assign q[i] = f_q;
      end
   endgenerate

endmodule

// File: rtl/txcsr_ctrl.sv
module txcsr_ctrl #(
   parameter int IDLE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDLE_W-1:0] idle_d,
   input  logic              uwait_d,
   output logic [IDLE_W-1:0] idle_q,
   output logic              uwait_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_q  <= '0;
         uwait_q <= 1'b0;
      end else if (wr_en) begin
         idle_q  <= idle_d;
         uwait_q <= uwait_d;
      end
   end

endmodule

// File: rtl/tx_cmd_status.sv
module tx_cmd_status
   import txcsr_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int CMD_W      = 4,
   parameter int IDLE_W     = 3,
   parameter int SEL_W      = 2,
   parameter bit REG_PULSES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic [1:0]        mode_i,
   input  logic              frame_en_i,
   input  logic              ev_pre_i,
   input  logic              ev_idle_i,
   input  logic              ev_abort_i,
   input  logic              ev_eom_i,
   input  logic              ev_crc_i,
   input  logic              ev_under_i,
   input  logic              all_sent_i,
   input  logic              fifo_empty_i,
   output logic              crc_clr_o,
   output logic              send_frame_o,
   output logic              send_abort_o,
   output logic              dle_on_o,
   output logic              dle_off_o,
   output logic              eom_clr_o,
   output logic              eom_set_o,
   output logic [SEL_W-1:0]  hi_sel_o,
   output logic [IDLE_W-1:0] idle_sel_o,
   output logic              under_wait_o
);

   localparam int CMD_LSB  = DATA_W - CMD_W;
   localparam int UWAIT_B  = CMD_LSB - 1;
   localparam int IDLE_LSB = UWAIT_B - IDLE_W;

   generate
      if (DATA_W != 16) begin : g_bad_w
         $error("tx_cmd_status: DATA_W must be 16");
      end
      if (CMD_W != 4) begin : g_bad_cmd
         $error("tx_cmd_status: CMD_W must be 4");
      end
      if (IDLE_W != 3) begin : g_bad_idle
         $error("tx_cmd_status: IDLE_W must be 3");
      end
      if (SEL_W < 2) begin : g_bad_sel
         $error("tx_cmd_status: SEL_W must be at least 2");
      end
   endgenerate

   logic [NUM_PULSE-1:0] pulse;
   logic [NUM_FLAG-1:0]  ev_vec;
   logic [NUM_FLAG-1:0]  clr_vec;
   logic [NUM_FLAG-1:0]  flag_q;
   logic                 unused_bits;

   assign ev_vec = {ev_under_i, ev_crc_i, ev_eom_i, ev_abort_i, ev_idle_i, ev_pre_i};
   assign unused_bits = ^{wr_data_i[BIT_ALLSENT], wr_data_i[BIT_EMPTY]};

   generate
      for (genvar k = 0; k < NUM_FLAG; k++) begin : g_clr
         assign clr_vec[k] = wr_en_i & wr_data_i[FLAG_POS[k]];
      end
   endgenerate

   txcsr_cmd_dec #(
      .CMD_W      (CMD_W),
      .SEL_W      (SEL_W),
      .REG_PULSES (REG_PULSES)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en_i),
      .cmd      (wr_data_i[DATA_W-1:CMD_LSB]),
      .mode     (mode_i),
      .frame_en (frame_en_i),
      .pulse    (pulse),
      .hi_sel   (hi_sel_o)
   );

   txcsr_flags #(
      .N (NUM_FLAG)
   ) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ev_vec),
      .clr   (clr_vec),
      .q     (flag_q)
   );

   txcsr_ctrl #(
      .IDLE_W (IDLE_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_i),
      .idle_d  (wr_data_i[UWAIT_B-1:IDLE_LSB]),
      .uwait_d (wr_data_i[UWAIT_B]),
      .idle_q  (idle_sel_o),
      .uwait_q (under_wait_o)
   );

   always_comb begin
      rd_data_o = '0;
      for (int k = 0; k < NUM_FLAG; k++)
         rd_data_o[FLAG_POS[k]] = flag_q[k];
      rd_data_o[BIT_ALLSENT]            = all_sent_i;
      rd_data_o[BIT_EMPTY]              = fifo_empty_i;
      rd_data_o[UWAIT_B]                = under_wait_o;
      rd_data_o[UWAIT_B-1:IDLE_LSB]     = idle_sel_o;
   end

   assign crc_clr_o    = pulse[P_CRC];
   assign send_frame_o = pulse[P_FRAME];
   assign send_abort_o = pulse[P_ABORT];
   assign dle_on_o     = pulse[P_DLEON];
   assign dle_off_o    = pulse[P_DLEOFF];
   assign eom_clr_o    = pulse[P_EOMCLR];
   assign eom_set_o    = pulse[P_EOMSET];

endmodule

// File: rtl/tx_cmd_status_chk.sv
module tx_cmd_status_chk #(
   parameter bit REG_PULSES = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en_i,
   input logic [15:0] wr_data_i,
   input logic [15:0] rd_data_o,
   input logic [1:0]  mode_i,
   input logic        frame_en_i,
   input logic        ev_under_i,
   input logic        crc_clr_o,
   input logic        send_frame_o,
   input logic        send_abort_o,
   input logic        dle_on_o,
   input logic        dle_off_o,
   input logic        eom_clr_o,
   input logic        eom_set_o
);

   AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({crc_clr_o, send_frame_o, send_abort_o, dle_on_o, dle_off_o, eom_clr_o, eom_set_o})); // R14

   AST_ABORT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      send_abort_o |-> ((REG_PULSES ? $past(mode_i) : mode_i) == 2'b10)); // R7

   AST_DLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (dle_on_o || dle_off_o) |-> ((REG_PULSES ? $past(mode_i) : mode_i) == 2'b11)); // R8

   AST_EOM_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (eom_clr_o || eom_set_o) |-> ((REG_PULSES ? $past(mode_i) : mode_i) != 2'b00)); // R9

   AST_FRAME_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      send_frame_o |-> (REG_PULSES ? $past(frame_en_i) : frame_en_i)); // R6

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rd_data_o[1]) && !($past(wr_en_i) && $past(wr_data_i[1])))
      |-> rd_data_o[1]); // R11

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ev_under_i)) |-> rd_data_o[1]); // R12

   AST_CMD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(wr_en_i) |-> (rd_data_o[15:12] == 4'h0)); // R3

endmodule

bind tx_cmd_status tx_cmd_status_chk #(
   .REG_PULSES (REG_PULSES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en_i      (wr_en_i),
   .wr_data_i    (wr_data_i),
   .rd_data_o    (rd_data_o),
   .mode_i       (mode_i),
   .frame_en_i   (frame_en_i),
   .ev_under_i   (ev_under_i),
   .crc_clr_o    (crc_clr_o),
   .send_frame_o (send_frame_o),
   .send_abort_o (send_abort_o),
   .dle_on_o     (dle_on_o),
   .dle_off_o    (dle_off_o),
   .eom_clr_o    (eom_clr_o),
   .eom_set_o    (eom_set_o)
);

// File: tb/tx_cmd_status_bench.sv
`timescale 1ns/1ps
module tx_cmd_status_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        r_wr = 1'b0;
   logic [15:0] r_wd = '0;
   logic [1:0]  r_mode = 2'b00;
   logic        r_fe = 1'b0;
   logic [5:0]  r_ev = '0;
   logic        r_as = 1'b0;
   logic        r_em = 1'b0;

   logic [15:0] rd;
   logic        crc_clr, send_frame, send_abort, dle_on, dle_off, eom_clr, eom_set;
   logic [1:0]  hi_sel;
   logic [2:0]  idle_sel;
   logic        under_wait;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [15:0] m_fl = '0;
   logic [2:0]  m_idle = '0;
   logic        m_uw = 1'b0;
   logic [1:0]  m_sel = '0;
   logic [6:0]  m_pul = '0;
   string       m_ptag = "R10";

   always #4 clk = ~clk;

   tx_cmd_status u_tx_cmd_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en_i      (r_wr),
      .wr_data_i    (r_wd),
      .rd_data_o    (rd),
      .mode_i       (r_mode),
      .frame_en_i   (r_fe),
      .ev_pre_i     (r_ev[0]),
      .ev_idle_i    (r_ev[1]),
      .ev_abort_i   (r_ev[2]),
      .ev_eom_i     (r_ev[3]),
      .ev_crc_i     (r_ev[4]),
      .ev_under_i   (r_ev[5]),
      .all_sent_i   (r_as),
      .fifo_empty_i (r_em),
      .crc_clr_o    (crc_clr),
      .send_frame_o (send_frame),
      .send_abort_o (send_abort),
      .dle_on_o     (dle_on),
      .dle_off_o    (dle_off),
      .eom_clr_o    (eom_clr),
      .eom_set_o    (eom_set),
      .hi_sel_o     (hi_sel),
      .idle_sel_o   (idle_sel),
      .under_wait_o (under_wait)
   );

   function automatic logic [6:0] exp_pulses(logic wr, logic [3:0] cmd, logic [1:0] md, logic fe);
      logic [6:0] p = '0;
      if (wr) begin
         case (cmd)
            4'b0010: p[0] = 1'b1;
            4'b1000: p[1] = fe;
            4'b1001: p[2] = (md == 2'b10);
            4'b1100: p[3] = (md == 2'b11);
            4'b1101: p[4] = (md == 2'b11);
            4'b1110: p[5] = (md != 2'b00);
            4'b1111: p[6] = (md != 2'b00);
            default: ;
         endcase
      end
      return p;
   endfunction

   function automatic string cmd_tag(logic [3:0] cmd);
      case (cmd)
         4'b0010:                   return "R4";
         4'b0101, 4'b0110, 4'b0111: return "R5";
         4'b1000:                   return "R6";
         4'b1001:                   return "R7";
         4'b1100, 4'b1101:          return "R8";
         4'b1110, 4'b1111:          return "R9";
         default:                   return "R10";
      endcase
   endfunction

   function automatic logic [15:0] exp_rd();
      logic [15:0] e = m_fl;
      e[11]   = m_uw;
      e[10:8] = m_idle;
      e[2]    = r_as;
      e[0]    = r_em;
      return e;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_edge();
      int fpos [6] = '{7, 6, 5, 4, 3, 1};
      m_pul  = exp_pulses(r_wr, r_wd[15:12], r_mode, r_fe);
      m_ptag = r_wr ? cmd_tag(r_wd[15:12]) : "R10";
      for (int k = 0; k < 6; k++)
         m_fl[fpos[k]] = r_ev[k] | (m_fl[fpos[k]] & ~(r_wr & r_wd[fpos[k]]));
      if (r_wr) begin
         m_idle = r_wd[10:8];
         m_uw   = r_wd[11];
         case (r_wd[15:12])
            4'b0101: m_sel = 2'd0;
            4'b0110: m_sel = 2'd1;
            4'b0111: m_sel = 2'd2;
            default: ;
         endcase
      end
   endtask

   task automatic compare_all();
      chk("R11", "rd_data", {16'h0, rd}, {16'h0, exp_rd()});
      chk("R3", "cmd nibble", {28'h0, rd[15:12]}, 32'h0);
      chk(m_ptag, "pulses", {25'h0, eom_set, eom_clr, dle_off, dle_on, send_abort, send_frame, crc_clr},
          {25'h0, m_pul});
      chk("R5", "hi_sel", {30'h0, hi_sel}, {30'h0, m_sel});
      chk("R2", "ctrl", {28'h0, under_wait, idle_sel}, {28'h0, m_uw, m_idle});
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle_inputs();
      r_wr = 1'b0;
      r_wd = '0;
      r_ev = '0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "rd_data after reset", {16'h0, rd}, 32'h0);
      chk("R1", "pulses after reset", {25'h0, eom_set, eom_clr, dle_off, dle_on, send_abort, send_frame, crc_clr}, 32'h0);
      chk("R1", "hi_sel/idle/uw after reset", {26'h0, hi_sel, under_wait, idle_sel}, 32'h0);

      // R3, R2: command nibble reads zero, control bits stored
      r_wr = 1'b1; r_wd = 16'hFB00; r_mode = 2'b00;
      step();
      chk("R3", "nibble after 0xF write", {28'h0, rd[15:12]}, 32'h0);
      chk("R2", "idle_sel loaded", {29'h0, idle_sel}, 32'h3);
      chk("R9", "eom_set ignored in async", {31'h0, eom_set}, 32'h0);
      idle_inputs();
      step();
      chk("R2", "ctrl held without write", {28'h0, under_wait, idle_sel}, 32'hB);

      // R7: abort gated by mode
      r_wr = 1'b1; r_wd = 16'h9000; r_mode = 2'b01;
      step();
      chk("R7", "abort ignored in sync", {31'h0, send_abort}, 32'h0);
      r_mode = 2'b10;
      step();
      chk("R7", "abort in framing mode", {31'h0, send_abort}, 32'h1);
      idle_inputs();
      step();
      chk("R7", "abort pulse one cycle", {31'h0, send_abort}, 32'h0);

      // R8: DLE commands gated
      r_wr = 1'b1; r_wd = 16'hC000; r_mode = 2'b01;
      step();
      chk("R8", "dle_on ignored in sync", {31'h0, dle_on}, 32'h0);
      r_mode = 2'b11;
      step();
      chk("R8", "dle_on in transparent", {31'h0, dle_on}, 32'h1);

      // R6: send frame gate
      r_wd = 16'h8000; r_fe = 1'b0;
      step();
      chk("R6", "frame ignored without enable", {31'h0, send_frame}, 32'h0);
      r_fe = 1'b1;
      step();
      chk("R6", "frame with enable", {31'h0, send_frame}, 32'h1);

      // R5, R10: select held across reserved codes
      r_wd = 16'h6000;
      step();
      chk("R5", "hi_sel interrupt level", {30'h0, hi_sel}, 32'h1);
      r_wd = 16'hA000;
      step();
      chk("R10", "reserved keeps hi_sel", {30'h0, hi_sel}, 32'h1);

      // R12: set wins over clear
      idle_inputs();
      r_ev[5] = 1'b1;
      step();
      r_wr = 1'b1; r_wd = 16'h0002; r_ev[5] = 1'b1;
      step();
      chk("R12", "underrun set wins", {31'h0, rd[1]}, 32'h1);
      r_ev = '0;
      step();
      chk("R11", "underrun cleared by write one", {31'h0, rd[1]}, 32'h0);

      // R13: live bits follow inputs, writes ignored
      idle_inputs();
      r_wr = 1'b1; r_wd = 16'h0005; r_as = 1'b0; r_em = 1'b0;
      step();
      chk("R13", "live bits ignore write", {30'h0, rd[2], rd[0]}, 32'h0);
      r_wr = 1'b0; r_as = 1'b1; r_em = 1'b1;
      #1;
      chk("R13", "live bits follow inputs", {30'h0, rd[2], rd[0]}, 32'h3);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         r_wr   = ($urandom % 2) == 0;
         r_wd   = 16'($urandom);
         r_mode = 2'($urandom);
         r_fe   = ($urandom % 2) == 0;
         for (int k = 0; k < 6; k++)
            r_ev[k] = ($urandom % 4) == 0;
         r_as   = ($urandom % 2) == 0;
         r_em   = ($urandom % 2) == 0;
         step();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule